// File: doc/BRIEF.md
# Redundant Tile Voter with Spare Substitution

This block takes the output words of a pool of identical compute tiles. At any moment three of them form the active triad; the rest wait as spares or sit in a repair flow. A selection stage routes the three active words to a bitwise two-of-three voter. The voter yields the corrected word, a 2-bit health code naming the minority slot, and a flag for the case where no two words match.

When one slot disagrees, a small manager state machine retires the tile in that slot. It puts the lowest-numbered available spare into the same slot and marks the retired tile as faulted. It then spends one settle cycle in which no further swap is allowed, so a replacement that has not yet caught up cannot trigger a second swap. Faulted tiles raise a repair request. An external repair agent acknowledges each request, which moves the tile to repairing, and later pulses a done line, which returns the tile to the spare pool. A background scan input can also mark an idle spare as faulted, which sends it through the same repair flow.

The manager has two named states. WATCH is the normal state: a correctable mismatch with a spare available takes the transition "swap" into SETTLE. From SETTLE the only transition, "resume", leads back to WATCH after exactly one cycle. Each tile has its own state register, which holds active, spare, faulted or repairing.

Top module: `tile_vote_mgr`

## Requirements
- R1: After reset, tiles 0, 1 and 2 fill slots 0, 1 and 2. All other tiles are spares, the health code is 2'b00, the uncorrectable and no-spare flags are low, and no repair request is raised.
- R2: `voted_o` is the bitwise two-of-three majority of the three words selected by the active slots. It is combinational from the tile inputs.
- R3: The health code is 2'b00 when all three active words are equal. It is 2'b01, 2'b10 or 2'b11 when slot 0, 1 or 2 is the single disagreeing word and the other two are equal.
- R4: When all three active words differ, `uncorr_o` is 1 and the health code is 2'b00. No substitution happens, however long the condition lasts.
- R5: In WATCH, a nonzero health code with a spare available causes a swap at the next clock edge. That slot then holds the lowest-numbered available spare, which becomes active (2'b00), and the retired tile becomes faulted (2'b10). A spare whose scan input is high in that cycle is not available.
- R6: In the cycle after a swap (SETTLE), the active set does not change, even if the health code is nonzero.
- R7: `no_spare_o` is 1 when no spare is available. A mismatch during that time leaves the active set unchanged, while the voter keeps correcting the output.
- R8: `repair_req_o[t]` is high while tile t is faulted. `repair_ack_i[t]` moves a faulted tile to repairing (2'b11). `repair_done_i[t]` moves a repairing tile to spare (2'b01). On tiles in any other state, both inputs have no effect.
- R9: `scan_fault_i[t]` moves a spare tile to faulted. It has no effect on an active tile.
- R10: Exactly three tiles are active at all times, and each slot index on `active_idx_o` names one of them. Slot k occupies bits [4k+3:4k]. Tile t's state occupies bits [2t+1:2t] of `tile_state_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tile_words_i | input | 126 | Tile output words, tile t at bits [14t+13:14t] |
| scan_fault_i | input | 9 | Background scan found tile t faulty |
| repair_ack_i | input | 9 | Repair agent accepted tile t |
| repair_done_i | input | 9 | Repair of tile t finished |
| voted_o | output | 14 | Majority-voted word |
| health_o | output | 2 | Minority slot code (00 = agreement) |
| uncorr_o | output | 1 | All three active words differ |
| no_spare_o | output | 1 | No spare available for substitution |
| active_idx_o | output | 12 | Tile index held by each of the three slots |
| tile_state_o | output | 18 | Per-tile state code |
| repair_req_o | output | 9 | Tile t awaits repair |

## Verification
The hardest situation to reach is a mismatch that persists into the settle cycle. In that situation the freshly inserted tile itself disagrees, so the only thing that prevents a second swap is the SETTLE state. The bench reaches it by corrupting a spare's word before that spare is chosen, so the replacement is wrong on arrival. A related case is a starved pool. To reach it, the bench faults every remaining spare through the scan input and then presents a mismatch for two edges. For the sweeps of the voter's combinational behaviour, the bench applies a corrupted word just after one clock edge and removes it before the next, so the manager never swaps.

// File: rtl/tile_vote_pkg.sv
package tile_vote_pkg;

    typedef enum logic [1:0] {
        TS_ACTIVE  = 2'b00,
        TS_SPARE   = 2'b01,
        TS_FAULTED = 2'b10,
        TS_REPAIR  = 2'b11
    } tile_st_t;

    typedef enum logic {
        MG_WATCH  = 1'b0,
        MG_SETTLE = 1'b1
    } mgr_st_t;

    localparam int SLOTS = 3;

endpackage

// File: rtl/tile_select.sv
module tile_select #(
    parameter int NUM_TILES = 9,
    parameter int WORD_W    = 14,
    parameter int IDX_W     = $clog2(NUM_TILES)
) (
    input  logic [NUM_TILES*WORD_W-1:0]               tile_words_i,
    input  logic [tile_vote_pkg::SLOTS*IDX_W-1:0]     slot_idx_i,
    output logic [tile_vote_pkg::SLOTS*WORD_W-1:0]    lanes_o
);

    for (genvar k = 0; k < tile_vote_pkg::SLOTS; k++) begin : g_lane
        logic [IDX_W-1:0]  sel;
        logic [WORD_W-1:0] word;
        assign sel = slot_idx_i[k*IDX_W +: IDX_W];
        always_comb begin
            word = '0;
            for (int t = 0; t < NUM_TILES; t++) begin
                if (sel == IDX_W'(t)) begin
                    word = tile_words_i[t*WORD_W +: WORD_W];
                end
            end
        end
        assign lanes_o[k*WORD_W +: WORD_W] = word;
    end

endmodule

// File: rtl/tmr_vote.sv
module tmr_vote #(
    parameter int WORD_W = 14
) (
    input  logic [3*WORD_W-1:0] lanes_i,
    output logic [WORD_W-1:0]   voted_o,
    output logic [1:0]          health_o,
    output logic                uncorr_o
);

    logic [WORD_W-1:0] w0, w1, w2;
    logic eq01, eq02, eq12;

    assign w0 = lanes_i[0*WORD_W +: WORD_W];
    assign w1 = lanes_i[1*WORD_W +: WORD_W];
    assign w2 = lanes_i[2*WORD_W +: WORD_W];

    assign eq01 = (w0 == w1);
    assign eq02 = (w0 == w2);
    assign eq12 = (w1 == w2);

    assign voted_o = (w0 & w1) | (w0 & w2) | (w1 & w2);

    always_comb begin
        health_o = 2'b00;
        uncorr_o = 1'b0;
        if (eq01 && eq12) begin
            health_o = 2'b00;
        end else if (eq12) begin
            health_o = 2'b01;
        end else if (eq02) begin
            health_o = 2'b10;
        end else if (eq01) begin
            health_o = 2'b11;
        end else begin
            uncorr_o = 1'b1;
        end
    end

endmodule

// File: rtl/spare_pick.sv
module spare_pick #(
    parameter int NUM_TILES = 9,
    parameter int IDX_W     = $clog2(NUM_TILES)
) (
    input  logic [NUM_TILES-1:0] avail_i,
    output logic                 found_o,
    output logic [IDX_W-1:0]     idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int t = NUM_TILES - 1; t >= 0; t--) begin
            if (avail_i[t]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(t);
            end
        end
    end

endmodule

// File: rtl/tile_vote_mgr.sv
module tile_vote_mgr
    import tile_vote_pkg::*;
#(
    parameter int NUM_TILES = 9,
    parameter int WORD_W    = 14,
    localparam int IDX_W    = $clog2(NUM_TILES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_TILES*WORD_W-1:0] tile_words_i,
    input  logic [NUM_TILES-1:0]        scan_fault_i,
    input  logic [NUM_TILES-1:0]        repair_ack_i,
    input  logic [NUM_TILES-1:0]        repair_done_i,
    output logic [WORD_W-1:0]           voted_o,
    output logic [1:0]                  health_o,
    output logic                        uncorr_o,
    output logic                        no_spare_o,
    output logic [SLOTS*IDX_W-1:0]      active_idx_o,
    output logic [2*NUM_TILES-1:0]      tile_state_o,
    output logic [NUM_TILES-1:0]        repair_req_o
);

    mgr_st_t                  mgr_q, mgr_d;
    tile_st_t                 tile_q [NUM_TILES];
    tile_st_t                 tile_d [NUM_TILES];
    logic [SLOTS*IDX_W-1:0]   slot_q, slot_d;
    logic [SLOTS*WORD_W-1:0]  lanes;
    logic [1:0]               health;
    logic                     uncorr;
    logic [NUM_TILES-1:0]     avail;
    logic                     found;
    logic [IDX_W-1:0]         pick_idx;
    logic [IDX_W-1:0]         fail_tile;
    logic [1:0]               fail_slot;
    logic                     do_swap;

    tile_select #(.NUM_TILES(NUM_TILES), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_sel (
        .tile_words_i (tile_words_i),
        .slot_idx_i   (slot_q),
        .lanes_o      (lanes)
    );

    tmr_vote #(.WORD_W(WORD_W)) u_vote (
        .lanes_i  (lanes),
        .voted_o  (voted_o),
        .health_o (health),
        .uncorr_o (uncorr)
    );

    for (genvar t = 0; t < NUM_TILES; t++) begin : g_avail
        assign avail[t] = (tile_q[t] == TS_SPARE) && !scan_fault_i[t];
    end

    spare_pick #(.NUM_TILES(NUM_TILES), .IDX_W(IDX_W)) u_pick (
        .avail_i (avail),
        .found_o (found),
        .idx_o   (pick_idx)
    );

    // Map the minority slot to the tile it holds.
    always_comb begin
        fail_slot = health - 2'd1;
        unique case (health)
            2'b01:   fail_tile = slot_q[0*IDX_W +: IDX_W];
            2'b10:   fail_tile = slot_q[1*IDX_W +: IDX_W];
            2'b11:   fail_tile = slot_q[2*IDX_W +: IDX_W];
            default: fail_tile = '0;
        endcase
    end

    assign do_swap = (mgr_q == MG_WATCH) && (health != 2'b00) && found;

    // Manager next state: WATCH -swap-> SETTLE -resume-> WATCH.
    always_comb begin
        unique case (mgr_q)
            MG_WATCH:  mgr_d = do_swap ? MG_SETTLE : MG_WATCH;
            MG_SETTLE: mgr_d = MG_WATCH;
            default:   mgr_d = MG_WATCH;
        endcase
    end

    // Per-tile and slot next state.
    always_comb begin
        slot_d = slot_q;
        for (int t = 0; t < NUM_TILES; t++) begin
            tile_d[t] = tile_q[t];
            unique case (tile_q[t])
                TS_ACTIVE: begin
                    if (do_swap && fail_tile == IDX_W'(t)) tile_d[t] = TS_FAULTED;
                end
                TS_SPARE: begin
                    if (scan_fault_i[t])                        tile_d[t] = TS_FAULTED;
                    else if (do_swap && pick_idx == IDX_W'(t))  tile_d[t] = TS_ACTIVE;
                end
                TS_FAULTED: begin
                    if (repair_ack_i[t]) tile_d[t] = TS_REPAIR;
                end
                TS_REPAIR: begin
                    if (repair_done_i[t]) tile_d[t] = TS_SPARE;
                end
                default: tile_d[t] = tile_q[t];
            endcase
        end
        for (int k = 0; k < SLOTS; k++) begin
            if (do_swap && fail_slot == 2'(k)) slot_d[k*IDX_W +: IDX_W] = pick_idx;
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mgr_q <= MG_WATCH;
            for (int k = 0; k < SLOTS; k++) slot_q[k*IDX_W +: IDX_W] <= IDX_W'(k);
            for (int t = 0; t < NUM_TILES; t++) tile_q[t] <= (t < SLOTS) ? TS_ACTIVE : TS_SPARE;
        end else begin
            mgr_q  <= mgr_d;
            slot_q <= slot_d;
            for (int t = 0; t < NUM_TILES; t++) tile_q[t] <= tile_d[t];
        end
    end

    // Outputs.
    always_comb begin
        health_o     = health;
        uncorr_o     = uncorr;
        no_spare_o   = !found;
        active_idx_o = slot_q;
        for (int t = 0; t < NUM_TILES; t++) begin
            tile_state_o[2*t +: 2] = tile_q[t];
            repair_req_o[t]        = (tile_q[t] == TS_FAULTED);
        end
    end

endmodule

// File: rtl/tile_vote_chk.sv
module tile_vote_chk #(
    parameter int NUM_TILES = 9,
    parameter int IDX_W     = $clog2(NUM_TILES)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_TILES-1:0]   scan_fault_i,
    input logic [NUM_TILES-1:0]   repair_ack_i,
    input logic [NUM_TILES-1:0]   repair_done_i,
    input logic [1:0]             health_o,
    input logic                   uncorr_o,
    input logic                   no_spare_o,
    input logic [3*IDX_W-1:0]     active_idx_o,
    input logic [2*NUM_TILES-1:0] tile_state_o
);

    logic [NUM_TILES-1:0] act_mask;
    logic                 slots_ok;

    always_comb begin
        for (int t = 0; t < NUM_TILES; t++) act_mask[t] = (tile_state_o[2*t +: 2] == 2'b00);
        slots_ok = 1'b1;
        for (int k = 0; k < 3; k++) begin
            logic hit;
            hit = 1'b0;
            for (int t = 0; t < NUM_TILES; t++) begin
                if (active_idx_o[k*IDX_W +: IDX_W] == IDX_W'(t) && act_mask[t]) hit = 1'b1;
            end
            if (!hit) slots_ok = 1'b0;
        end
    end

    a_r10_three_active: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act_mask) == 3);
    a_r10_slots_active: assert property (@(posedge clk) disable iff (!rst_n)
        slots_ok);
    a_r4_uncorr_code: assert property (@(posedge clk) disable iff (!rst_n)
        uncorr_o |-> health_o == 2'b00);
    a_r4_uncorr_no_swap: assert property (@(posedge clk) disable iff (!rst_n)
        uncorr_o |=> $stable(active_idx_o));
    a_r6_settle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_idx_o) |=> $stable(active_idx_o));
    a_r7_no_spare_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (no_spare_o && health_o != 2'b00) |=> $stable(active_idx_o));
    a_r5_swap_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active_idx_o) |-> $past(health_o) != 2'b00);

    for (genvar t = 0; t < NUM_TILES; t++) begin : g_tile
        a_r8_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
            (tile_state_o[2*t +: 2] == 2'b10 && repair_ack_i[t]) |=> tile_state_o[2*t +: 2] == 2'b11);
        a_r8_done_moves: assert property (@(posedge clk) disable iff (!rst_n)
            (tile_state_o[2*t +: 2] == 2'b11 && repair_done_i[t]) |=> tile_state_o[2*t +: 2] == 2'b01);
        a_r9_scan_spare: assert property (@(posedge clk) disable iff (!rst_n)
            (tile_state_o[2*t +: 2] == 2'b01 && scan_fault_i[t]) |=> tile_state_o[2*t +: 2] == 2'b10);
    end

endmodule

bind tile_vote_mgr tile_vote_chk #(.NUM_TILES(NUM_TILES), .IDX_W(IDX_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scan_fault_i  (scan_fault_i),
    .repair_ack_i  (repair_ack_i),
    .repair_done_i (repair_done_i),
    .health_o      (health_o),
    .uncorr_o      (uncorr_o),
    .no_spare_o    (no_spare_o),
    .active_idx_o  (active_idx_o),
    .tile_state_o  (tile_state_o)
);

// File: tb/tb_tile_vote_mgr.sv
module tb_tile_vote_mgr;

    localparam int NT = 9;
    localparam int WW = 14;
    localparam logic [WW-1:0] BASE = 14'h1A5C;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [WW-1:0]   tw [NT];
    logic [NT*WW-1:0] words;
    logic [NT-1:0]   scan = '0, ack = '0, done = '0;
    logic [WW-1:0]   voted;
    logic [1:0]      health;
    logic            uncorr, no_spare;
    logic [11:0]     aidx;
    logic [2*NT-1:0] tstate;
    logic [NT-1:0]   req;

    int n_checks = 0;
    int n_fail   = 0;
    bit reported = 1'b0;

    always #10 clk = ~clk;

    always_comb for (int t = 0; t < NT; t++) words[t*WW +: WW] = tw[t];

    tile_vote_mgr dut (
        .clk(clk), .rst_n(rst_n), .tile_words_i(words),
        .scan_fault_i(scan), .repair_ack_i(ack), .repair_done_i(done),
        .voted_o(voted), .health_o(health), .uncorr_o(uncorr),
        .no_spare_o(no_spare), .active_idx_o(aidx),
        .tile_state_o(tstate), .repair_req_o(req)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] slot(input int k);
        return aidx[4*k +: 4];
    endfunction

    function automatic logic [1:0] st(input int t);
        return tstate[2*t +: 2];
    endfunction

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        end
        $finish;
    endtask

    task automatic edge_sample();
        @(posedge clk);
        #5;
    endtask

    initial begin
        #4_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
    end

    initial begin
        for (int t = 0; t < NT; t++) tw[t] = BASE;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #2;
        // R1: reset state
        chk(aidx == {4'd2, 4'd1, 4'd0}, "R1 slots", aidx, {4'd2, 4'd1, 4'd0});
        chk(tstate == {{6{2'b01}}, {3{2'b00}}}, "R1 states", tstate, {{6{2'b01}}, {3{2'b00}}});
        chk(health == 2'b00 && !uncorr && !no_spare && req == '0, "R1 flags",
            {health, uncorr, no_spare, req}, 0);

        // R2/R3: single-slot corruption sweep, removed before the next edge
        for (int s = 0; s < 3; s++) begin
            for (int b = 0; b <= WW; b++) begin
                logic [WW-1:0] m;
                m = (b == WW) ? {WW{1'b1}} : (WW'(1) << b);
                @(negedge clk);
                tw[s] = BASE ^ m;
                #2;
                chk(voted == BASE, "R2 majority single", voted, BASE);
                chk(health == 2'(s + 1) && !uncorr, "R3 health code", health, s + 1);
                tw[s] = BASE;
            end
        end
        // R2/R4: three distinct words
        for (int i = 0; i < 16; i++) begin
            logic [WW-1:0] a, b2, c, e;
            a  = BASE + WW'(i * 37);
            b2 = a ^ WW'(i + 1);
            c  = a ^ (WW'(i + 1) << 5);
            e  = (a & b2) | (a & c) | (b2 & c);
            @(negedge clk);
            tw[0] = a; tw[1] = b2; tw[2] = c;
            #2;
            chk(voted == e, "R2 bitwise majority", voted, e);
            chk(uncorr && health == 2'b00, "R4 uncorr code", {uncorr, health}, 3'b100);
            tw[0] = BASE; tw[1] = BASE; tw[2] = BASE;
        end
        edge_sample();
        chk(aidx == {4'd2, 4'd1, 4'd0}, "R3 sweep caused no swap", aidx, {4'd2, 4'd1, 4'd0});

        // R5/R6: slot 1 fails, its replacement (tile 3) arrives wrong
        @(negedge clk);
        tw[1] = BASE ^ 14'h1;
        tw[3] = BASE ^ 14'h2;
        edge_sample();
        chk(slot(1) == 4'd3, "R5 lowest spare in slot", slot(1), 3);
        chk(st(1) == 2'b10 && st(3) == 2'b00, "R5 states after swap", {st(1), st(3)}, 4'b1000);
        chk(req[1] == 1'b1, "R8 request raised", req[1], 1);
        chk(health == 2'b10, "R3 replacement mismatch", health, 2);
        edge_sample();
        chk(slot(1) == 4'd3 && st(4) == 2'b01, "R6 settle blocks swap", {slot(1), st(4)}, {4'd3, 2'b01});
        @(negedge clk);
        tw[3] = BASE;
        #2;
        chk(health == 2'b00 && voted == BASE, "R9 retired tile data ignored", health, 0);

        // R8: acknowledge and done, plus ignored pulses
        @(negedge clk);
        ack[1] = 1'b1; ack[5] = 1'b1; done[6] = 1'b1;
        edge_sample();
        chk(st(1) == 2'b11 && req[1] == 1'b0, "R8 ack to repairing", st(1), 3);
        chk(st(5) == 2'b01 && st(6) == 2'b01, "R8 ack/done ignored on spare", {st(5), st(6)}, 4'b0101);
        @(negedge clk);
        ack = '0; done = '0; done[1] = 1'b1;
        edge_sample();
        chk(st(1) == 2'b01, "R8 done to spare", st(1), 1);
        @(negedge clk);
        done = '0;

        // R9: scan on spare vs active
        @(negedge clk);
        scan[4] = 1'b1; scan[0] = 1'b1;
        edge_sample();
        chk(st(4) == 2'b10, "R9 scan faults spare", st(4), 2);
        chk(st(0) == 2'b00 && slot(0) == 4'd0, "R9 scan ignored on active", {st(0), slot(0)}, 0);
        @(negedge clk);
        scan = '0;
        tw[1] = BASE;

        // R5: repaired tile 1 is the lowest spare
        @(negedge clk);
        tw[0] = BASE ^ 14'h3;
        edge_sample();
        chk(slot(0) == 4'd1 && st(0) == 2'b10, "R5 repaired tile reused", {slot(0), st(0)}, {4'd1, 2'b10});
        @(negedge clk);
        tw[0] = BASE;
        edge_sample();

        // R5: lowest spare excluded by a same-cycle scan fault
        @(negedge clk);
        tw[2] = BASE ^ 14'h4;
        scan[5] = 1'b1;
        edge_sample();
        chk(slot(2) == 4'd6, "R5 scanned spare skipped", slot(2), 6);
        chk(st(5) == 2'b10 && st(2) == 2'b10, "R5 both faulted", {st(5), st(2)}, 4'b1010);
        @(negedge clk);
        scan = '0;
        tw[2] = BASE;
        edge_sample();

        // R7: exhaust the pool
        @(negedge clk);
        scan[7] = 1'b1; scan[8] = 1'b1;
        edge_sample();
        @(negedge clk);
        scan = '0;
        #2;
        chk(no_spare == 1'b1, "R7 no spare flag", no_spare, 1);
        tw[3] = BASE ^ 14'h5;
        edge_sample();
        edge_sample();
        chk(aidx == {4'd6, 4'd3, 4'd1}, "R7 degraded triad held", aidx, {4'd6, 4'd3, 4'd1});
        chk(voted == BASE && health == 2'b10, "R7 output still corrected", voted, BASE);
        @(negedge clk);
        tw[3] = BASE;

        // R4: uncorrectable with a spare available
        ack[7] = 1'b1;
        edge_sample();
        @(negedge clk);
        ack = '0; done[7] = 1'b1;
        edge_sample();
        @(negedge clk);
        done = '0;
        #2;
        chk(st(7) == 2'b01 && !no_spare, "R8 tile 7 back in pool", st(7), 1);
        tw[1] = BASE ^ 14'h1;
        tw[3] = BASE ^ 14'h2;
        edge_sample();
        edge_sample();
        chk(aidx == {4'd6, 4'd3, 4'd1} && uncorr, "R4 no substitution", aidx, {4'd6, 4'd3, 4'd1});
        chk(st(7) == 2'b01, "R4 spare untouched", st(7), 1);
        chk($countones({st(0) == 2'b00, st(1) == 2'b00, st(3) == 2'b00, st(6) == 2'b00}) == 3,
            "R10 three active", tstate, 0);

        report();
    end

endmodule